// File: doc/BRIEF.md
# Modem Control Line Monitor

This block watches two slow modem inputs, clear-to-send and carrier-detect, and drives the request-to-send output. Both inputs are asynchronous. Each one is brought into the system-clock domain and then looked at only on a periodic sample tick. A new level is accepted only once it has been seen on two sample ticks in a row. A one-off sample that differs from the settled level is discarded. The block uses only the system clock, so monitoring continues when the serial bit clocks are stopped.

Host traffic uses three single-cycle inputs and one output channel. A pulse on the write strobe loads the request-to-send level. A pulse on the read strobe asks for a snapshot of all three lines. A mode input allows or blocks change events. Read snapshots and change events leave through one status channel with a valid/ready handshake. Each kind of item waits in its own pending flag until the channel takes it. An item placed on the channel stays there unchanged until it is accepted.

Top module: `modem_line_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `rts_pin` is 1 and `stat_valid` is 0 until an item is queued.
- R2: The cycle after a pulse on `rts_wr_valid`, `rts_pin` equals the `rts_wr_data` value that came with that pulse.
- R3: Each input is sampled once every `TICK_CYCLES` system-clock cycles. Its settled level changes only when two successive samples both show the new level. A pulse shorter than half a period never changes the settled level and never raises an event.
- R4: After an input moves to a new steady level, no change event appears within `TICK_CYCLES-2` cycles. The event appears within `2*TICK_CYCLES+8` cycles.
- R5: The first sample after reset loads the settled level of each input without raising a change event.
- R6: With `report_en` = 1, a confirmed clear-to-send change queues a status item of kind 2'b01. A confirmed carrier-detect change queues kind 2'b10.
- R7: With `report_en` = 0, a confirmed change queues nothing, but the settled level still follows the input, as a later read snapshot shows.
- R8: A pulse on `rd_req` queues an item of kind 2'b00. Every item's `stat_data` holds the levels at the time it is loaded into the channel: bit 0 is settled clear-to-send, bit 1 is settled carrier-detect, bit 2 is `rts_pin`.
- R9: While `stat_valid` is 1 and `stat_ready` is 0, `stat_valid`, `stat_kind` and `stat_data` stay unchanged. An item is removed only by a handshake. Repeated changes of one kind while that kind is already waiting become a single item.
- R10: When the channel frees up and several kinds are waiting, the read snapshot goes first, then the clear-to-send change, then the carrier-detect change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_pin | input | 1 | Clear-to-send line, asynchronous |
| cd_pin | input | 1 | Carrier-detect line, asynchronous |
| rts_pin | output | 1 | Request-to-send line |
| report_en | input | 1 | Mode bit that allows change events |
| rts_wr_valid | input | 1 | One-cycle strobe that writes the request-to-send level |
| rts_wr_data | input | 1 | Level written by the strobe |
| rd_req | input | 1 | One-cycle strobe that requests a pin snapshot |
| stat_valid | output | 1 | A status item is on the channel |
| stat_ready | input | 1 | The host accepts the item in this cycle |
| stat_kind | output | 2 | 00 snapshot, 01 clear-to-send change, 10 carrier-detect change |
| stat_data | output | 3 | {rts, carrier-detect, clear-to-send} levels |

## Verification
The bench drives pulses shorter than half a sample period. A filter that trusts a single sample would report these as events and show the pulse level in the next snapshot. It measures how long a real change takes to become an event, which catches a filter that skips confirmation or waits an extra period. It checks that no event follows reset and that blocked events still update the levels, so a design that reports its first sample, or stops tracking when the mode bit is clear, gives a wrong kind or wrong data. It stalls the channel while all three kinds wait and while one input toggles twice. A design with the wrong priority, or one that loses or duplicates coalesced events, then drains in the wrong order or drains the wrong number of items.

// File: rtl/mlm_pkg.sv
// Shared constants for the modem line monitor.
// Assumes: the status item kind equals the index of its pending flag.
package mlm_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_SNAPSHOT = 2'b00,
        KIND_CTS_CHG  = 2'b01,
        KIND_CD_CHG   = 2'b10
    } stat_kind_e;

    localparam int NUM_LINES = 2;   // monitored inputs: 0 = clear-to-send, 1 = carrier-detect
    localparam int NUM_KINDS = 3;   // snapshot, cts change, cd change

endpackage

// File: rtl/mlm_tick.sv
// Sample tick generator.
// Produces a one-cycle pulse every TICK_CYCLES system clocks.
// Assumes: TICK_CYCLES >= 2, and the count restarts from zero on reset.
module mlm_tick #(
    parameter int TICK_CYCLES = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Free-running period counter with a registered pulse at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/mlm_line_filter.sv
// One monitored input: synchronizer, then two-sample confirmation.
// On the first tick after reset the settled level is loaded silently.
// Later, a sample that differs from the settled level arms a candidate.
// The next tick either confirms it, if the sample still differs, or drops it.
// Assumes: SYNC_STAGES >= 2 and tick_i is a single-cycle pulse.
module mlm_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic tick_i,
    output logic level_o,
    output logic chg_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   primed_q;
    logic                   cand_q;
    logic                   smp;

    // Synchronizer chain into the system-clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign smp = sync_q[SYNC_STAGES-1];

    // Confirmation state machine evaluated on each sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            cand_q   <= 1'b0;
            level_o  <= 1'b0;
            chg_o    <= 1'b0;
        end else begin
            chg_o <= 1'b0;
            if (tick_i) begin
                if (!primed_q) begin
                    primed_q <= 1'b1;
                    level_o  <= smp;
                end else if (!cand_q) begin
                    cand_q <= (smp != level_o);
                end else begin
                    cand_q <= 1'b0;
                    if (smp != level_o) begin
                        level_o <= smp;
                        chg_o   <= 1'b1;
                    end
                end
            end
        end
    end

    // R3
    level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(level_o));

    // R3
    no_single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && primed_q && !cand_q) |=> $stable(level_o));

    // R5
    silent_prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !primed_q) |=> !chg_o);

endmodule

// File: rtl/mlm_status_port.sv
// Pending flags and the output stage of the status channel.
// One flag per item kind. A new set wins over a clear in the same cycle.
// The output register is reloaded only when it is empty or being accepted.
// Assumes: the kind code equals the flag index, and a lower index has priority.
module mlm_status_port
    import mlm_pkg::*;
#(
    parameter int DATA_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] set_i,
    input  logic [DATA_W-1:0]    levels_i,
    output logic                 valid_o,
    input  logic                 ready_i,
    output logic [KIND_W-1:0]    kind_o,
    output logic [DATA_W-1:0]    data_o
);
    logic [NUM_KINDS-1:0] pend_q;
    logic [NUM_KINDS-1:0] pick;
    logic [KIND_W-1:0]    pick_idx;
    logic                 load;

    // Fixed priority pick: the lowest pending index wins.
    always_comb begin
        pick     = '0;
        pick_idx = '0;
        for (int k = NUM_KINDS - 1; k >= 0; k--) begin
            if (pend_q[k]) begin
                pick     = '0;
                pick[k]  = 1'b1;
                pick_idx = KIND_W'(k);
            end
        end
    end

    assign load = (!valid_o || ready_i) && (|pend_q);

    // Pending flags: cleared on load, set by new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(load ? pick : '0)) | set_i;
    end

    // Output stage: holds an item until it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            kind_o  <= '0;
            data_o  <= '0;
        end else if (load) begin
            valid_o <= 1'b1;
            kind_o  <= pick_idx;
            data_o  <= levels_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

    // R9
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(kind_o) && $stable(data_o)));

    // R6
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (kind_o != 2'b11));

    // R9
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[0] && valid_o && !ready_i) |=> pend_q[0]);

endmodule

// File: rtl/modem_line_monitor.sv
// Modem control line monitor top.
// Confirms clear-to-send and carrier-detect levels on a slow tick.
// Holds the request-to-send level written by the host.
// Serves snapshots and change events over one valid/ready status channel.
// Assumes: only the system clock is used, TICK_CYCLES >= 8, and host strobes last one cycle.
module modem_line_monitor
    import mlm_pkg::*;
#(
    parameter int TICK_CYCLES = 1600000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_pin,
    input  logic       cd_pin,
    output logic       rts_pin,
    input  logic       report_en,
    input  logic       rts_wr_valid,
    input  logic       rts_wr_data,
    input  logic       rd_req,
    output logic       stat_valid,
    input  logic       stat_ready,
    output logic [1:0] stat_kind,
    output logic [2:0] stat_data
);
    localparam int DATA_W = NUM_LINES + 1;

    logic                 tick;
    logic [NUM_LINES-1:0] pins;
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] chg;
    logic [NUM_KINDS-1:0] set_vec;
    logic [DATA_W-1:0]    levels;

    assign pins = {cd_pin, cts_pin};

    mlm_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        mlm_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pins[g]),
            .tick_i  (tick),
            .level_o (level[g]),
            .chg_o   (chg[g])
        );
    end

    // Request-to-send register, high out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)            rts_pin <= 1'b1;
        else if (rts_wr_valid) rts_pin <= rts_wr_data;
    end

    assign levels  = {rts_pin, level};
    assign set_vec = {chg & {NUM_LINES{report_en}}, rd_req};

    mlm_status_port #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .levels_i (levels),
        .valid_o  (stat_valid),
        .ready_i  (stat_ready),
        .kind_o   (stat_kind),
        .data_o   (stat_data)
    );

    // R2
    rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts_wr_valid |=> (rts_pin == $past(rts_wr_data)));

    // R2
    rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_wr_valid |=> $stable(rts_pin));

endmodule

// File: tb/modem_line_monitor_bench.sv
module modem_line_monitor_bench;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_pin = 1'b1;
    logic       cd_pin = 1'b1;
    logic       rts_pin;
    logic       report_en = 1'b1;
    logic       rts_wr_valid = 1'b0;
    logic       rts_wr_data = 1'b0;
    logic       rd_req = 1'b0;
    logic       stat_valid;
    logic       stat_ready = 1'b0;
    logic [1:0] stat_kind;
    logic [2:0] stat_data;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    modem_line_monitor #(.TICK_CYCLES(N), .SYNC_STAGES(2)) u_modem_line_monitor (
        .clk(clk), .rst_n(rst_n), .cts_pin(cts_pin), .cd_pin(cd_pin), .rts_pin(rts_pin),
        .report_en(report_en), .rts_wr_valid(rts_wr_valid), .rts_wr_data(rts_wr_data),
        .rd_req(rd_req), .stat_valid(stat_valid), .stat_ready(stat_ready),
        .stat_kind(stat_kind), .stat_data(stat_data)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Check that an item of the given kind and data is on the channel, then accept it.
    task automatic pop(input string req, input int kind, input int data);
        chk(stat_valid == 1'b1, req, stat_valid, 1);
        chk(stat_kind == kind[1:0], req, stat_kind, kind);
        chk(stat_data == data[2:0], req, stat_data, data);
        stat_ready = 1'b1;
        cyc(1);
        stat_ready = 1'b0;
    endtask

    task automatic snap(input string req, input int data);
        rd_req = 1'b1;
        cyc(1);
        rd_req = 1'b0;
        cyc(3);
        pop(req, 0, data);
    endtask

    task automatic drain();
        stat_ready = 1'b1;
        cyc(6);
        stat_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: values while reset is held
        chk(rts_pin == 1'b1, "R1", rts_pin, 1);
        chk(stat_valid == 1'b0, "R1", stat_valid, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(rts_pin == 1'b1, "R1", rts_pin, 1);

        // R5: the first sample raises no event
        cyc(4 * N);
        chk(stat_valid == 1'b0, "R5", stat_valid, 0);
        // R8: the snapshot shows all lines high
        snap("R8", 3'b111);
        chk(stat_valid == 1'b0, "R9", stat_valid, 0);

        // R4 and R6: a clear-to-send fall, latency window
        cts_pin = 1'b0;
        cyc(N - 2);
        chk(stat_valid == 1'b0, "R4", stat_valid, 0);
        cyc(N + 10);
        chk(stat_valid == 1'b1, "R4", stat_valid, 1);
        cyc(5);
        // R9: item held while stalled
        pop("R6", 1, 3'b110);

        // R3: a short pulse on carrier-detect is ignored
        cd_pin = 1'b0;
        cyc(N / 2);
        cd_pin = 1'b1;
        cyc(4 * N);
        chk(stat_valid == 1'b0, "R3", stat_valid, 0);
        snap("R3", 3'b110);

        // R7: with reporting blocked, the level is still tracked
        report_en = 1'b0;
        cd_pin = 1'b0;
        cyc(4 * N);
        chk(stat_valid == 1'b0, "R7", stat_valid, 0);
        snap("R7", 3'b100);
        report_en = 1'b1;

        // R2: request-to-send write
        rts_wr_data = 1'b0; rts_wr_valid = 1'b1;
        cyc(1);
        rts_wr_valid = 1'b0;
        chk(rts_pin == 1'b0, "R2", rts_pin, 0);
        snap("R2", 3'b000);
        rts_wr_data = 1'b1; rts_wr_valid = 1'b1;
        cyc(1);
        rts_wr_valid = 1'b0;
        chk(rts_pin == 1'b1, "R2", rts_pin, 1);

        // R10: the carrier-detect change waits before the clear-to-send change
        rd_req = 1'b1; cyc(1); rd_req = 1'b0; cyc(3);
        cd_pin = 1'b1;  cyc(3 * N + 4);
        cts_pin = 1'b1; cyc(3 * N + 4);
        rd_req = 1'b1; cyc(1); rd_req = 1'b0; cyc(3);
        pop("R10", 0, 3'b100);
        cyc(2);
        pop("R10", 0, 3'b111);
        cyc(2);
        pop("R10", 1, 3'b111);
        cyc(2);
        pop("R10", 2, 3'b111);
        cyc(2);
        chk(stat_valid == 1'b0, "R10", stat_valid, 0);

        // R9: two clear-to-send changes while stalled give one item
        rd_req = 1'b1; cyc(1); rd_req = 1'b0; cyc(3);
        cts_pin = 1'b0; cyc(3 * N + 4);
        cts_pin = 1'b1; cyc(3 * N + 4);
        pop("R9", 0, 3'b111);
        cyc(2);
        pop("R9", 1, 3'b111);
        cyc(2);
        chk(stat_valid == 1'b0, "R9", stat_valid, 0);

        // R8: sweep over all input level combinations
        for (int v = 0; v < 4; v++) begin
            cts_pin = v[0];
            cd_pin  = v[1];
            cyc(3 * N + 4);
            drain();
            snap("R8", 4 + v);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule